// File: doc/BRIEF.md
# Memory Type Range Resolver

This block resolves the memory type of a physical page when a translation is loaded into the TLB. It holds a small bank of programmable range registers. Each register has a page base, a page mask, an enable bit and a memory type. It also holds one default type, used for addresses that no range covers. A fill request supplies the physical page number and the memory type taken from the page-table entry's attribute bits. The block compares the page against every range once, combines the matching range types into one range type, and merges that with the page type. The result and a cacheable flag appear one cycle later, ready to be stored next to the new TLB entry. Later accesses read the stored type from the TLB and never come back to this block.

Writing a range register or the default type can change the type of pages that are already translated. For that reason, every such write produces a one-cycle pulse that tells the TLB to drop all of its entries, global entries included.

Top module: `memtype_resolver`

## Requirements
- R1: Memory types use a 3-bit code: UC=0, WC=1, WT=4, WP=5, WB=6. The reserved codes 2, 3 and 7 are treated as UC wherever they are written or supplied. The resolved type is always one of the five legal codes.
- R2: Base and mask are page numbers, meaning physical address bits 35:12 (4 KB granularity). Range i covers page P when its enable bit is set and (P & mask) equals (base & mask).
- R3: A page that no enabled range covers takes the default type.
- R4: When several ranges cover a page and their types differ, the range type is resolved in this order. If any of them is UC, the result is UC. If the set of types is exactly {WT, WB}, the result is WT. Any other mix gives UC. Ranges that agree on one type give that type.
- R5: The range type and the page type are merged as follows. If either is UC, the result is UC. Otherwise, if either is WC, the result is WC. Otherwise, if either is WT, the result is WT. Otherwise the range type is used.
- R6: res_cacheable is 1 exactly when the resolved type is WT, WP or WB. It is 0 for UC and WC.
- R7: res_valid is high in the cycle after a cycle with fill_req high, and low otherwise. res_type and res_cacheable belong to that fill.
- R8: tlb_flush_all is high for one cycle after every cycle in which cfg_we or def_we is high, and low after every other cycle.
- R9: A fill in the same cycle as a range or default write is resolved with the contents from before the write. The new contents apply from the next cycle on.
- R10: Reset clears every enable bit, sets the default type to UC, and holds res_valid and tlb_flush_all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one range register |
| cfg_idx | input | 3 | Index of the range register to write |
| cfg_base | input | 24 | Base page number for the range |
| cfg_mask | input | 24 | Page-number mask for the range |
| cfg_valid | input | 1 | Enable bit for the range |
| cfg_type | input | 3 | Memory type of the range |
| def_we | input | 1 | Write the default type |
| def_type | input | 3 | New default type |
| fill_req | input | 1 | Translation fill request |
| fill_pfn | input | 24 | Physical page number of the fill |
| fill_pat | input | 3 | Memory type from the page-table entry |
| res_valid | output | 1 | Resolved result is present |
| res_type | output | 3 | Resolved memory type |
| res_cacheable | output | 1 | Resolved type may be cached |
| tlb_flush_all | output | 1 | Invalidate every TLB entry, global entries included |

## Verification
A translation fill and a register write can fall in the same cycle. The fill must then be resolved against the old range contents, while the flush pulse still appears on the next cycle. The random sequence issues combined fill-and-write steps often, and a directed step rewrites the very range that covers the page being filled. The reference model computes each fill's expectation before it applies that step's write. A design that forwards the new contents into the fill, or drops the flush, therefore shows a wrong type or a missing pulse.

// File: rtl/memtype_pkg.sv
package memtype_pkg;

    typedef enum logic [2:0] {
        MT_UC = 3'd0,
        MT_WC = 3'd1,
        MT_WT = 3'd4,
        MT_WP = 3'd5,
        MT_WB = 3'd6
    } mem_type_e;

    localparam int NUM_KINDS = 5;
    localparam int K_UC = 0;
    localparam int K_WC = 1;
    localparam int K_WT = 2;
    localparam int K_WP = 3;
    localparam int K_WB = 4;

    typedef logic [NUM_KINDS-1:0] kind_set_t;

    typedef struct packed {
        logic      enable;
        mem_type_e kind;
    } range_attr_t;

    typedef struct packed {
        mem_type_e kind;
        logic      cacheable;
    } resolved_t;

    function automatic mem_type_e sanitize(input logic [2:0] code);
        case (code)
            3'd1:    return MT_WC;
            3'd4:    return MT_WT;
            3'd5:    return MT_WP;
            3'd6:    return MT_WB;
            default: return MT_UC;
        endcase
    endfunction

    function automatic kind_set_t kind_bit(input mem_type_e t);
        kind_set_t s;
        s = '0;
        case (t)
            MT_WC:   s[K_WC] = 1'b1;
            MT_WT:   s[K_WT] = 1'b1;
            MT_WP:   s[K_WP] = 1'b1;
            MT_WB:   s[K_WB] = 1'b1;
            default: s[K_UC] = 1'b1;
        endcase
        return s;
    endfunction

    function automatic mem_type_e single_kind(input kind_set_t s);
        if (s[K_WC]) return MT_WC;
        if (s[K_WT]) return MT_WT;
        if (s[K_WP]) return MT_WP;
        if (s[K_WB]) return MT_WB;
        return MT_UC;
    endfunction

    function automatic mem_type_e resolve_overlap(input kind_set_t s, input mem_type_e dflt);
        kind_set_t wt_wb;
        wt_wb = '0;
        wt_wb[K_WT] = 1'b1;
        wt_wb[K_WB] = 1'b1;
        if (s == '0)             return dflt;
        if ($countones(s) == 1)  return single_kind(s);
        if (s[K_UC])             return MT_UC;
        if (s == wt_wb)          return MT_WT;
        return MT_UC;
    endfunction

    function automatic mem_type_e merge_page(input mem_type_e rng, input mem_type_e pg);
        if (rng == MT_UC || pg == MT_UC) return MT_UC;
        if (rng == MT_WC || pg == MT_WC) return MT_WC;
        if (rng == MT_WT || pg == MT_WT) return MT_WT;
        return rng;
    endfunction

    function automatic logic is_cacheable(input mem_type_e t);
        return (t == MT_WT) || (t == MT_WP) || (t == MT_WB);
    endfunction

endpackage

// File: rtl/memtype_range_regs.sv
module memtype_range_regs
    import memtype_pkg::*;
#(
    parameter int N_RANGES = 8,
    parameter int PFN_W    = 24,
    localparam int IDX_W   = (N_RANGES > 1) ? $clog2(N_RANGES) : 1
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [PFN_W-1:0]                wr_base,
    input  logic [PFN_W-1:0]                wr_mask,
    input  logic                            wr_enable,
    input  logic [2:0]                      wr_type,
    input  logic                            dflt_we,
    input  logic [2:0]                      dflt_type,
    output logic [N_RANGES-1:0][PFN_W-1:0]  base_q,
    output logic [N_RANGES-1:0][PFN_W-1:0]  mask_q,
    output range_attr_t [N_RANGES-1:0]      attr_q,
    output mem_type_e                       dflt_q
);

    for (genvar i = 0; i < N_RANGES; i++) begin : g_entry
        logic hit_sel;
        assign hit_sel = wr_en && (wr_idx == IDX_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                base_q[i] <= '0;
                mask_q[i] <= '0;
                attr_q[i] <= '{enable: 1'b0, kind: MT_UC};
            end else if (hit_sel) begin
                base_q[i] <= wr_base;
                mask_q[i] <= wr_mask;
                attr_q[i] <= '{enable: wr_enable, kind: sanitize(wr_type)};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          dflt_q <= MT_UC;
        else if (dflt_we) dflt_q <= sanitize(dflt_type);
    end

endmodule

// File: rtl/memtype_range_match.sv
module memtype_range_match
    import memtype_pkg::*;
#(
    parameter int N_RANGES = 8,
    parameter int PFN_W    = 24
) (
    input  logic [PFN_W-1:0]                pfn,
    input  logic [N_RANGES-1:0][PFN_W-1:0]  base_q,
    input  logic [N_RANGES-1:0][PFN_W-1:0]  mask_q,
    input  range_attr_t [N_RANGES-1:0]      attr_q,
    output kind_set_t                       kinds
);

    logic [N_RANGES-1:0] hit;

    for (genvar i = 0; i < N_RANGES; i++) begin : g_cmp
        assign hit[i] = attr_q[i].enable &&
                        (((pfn ^ base_q[i]) & mask_q[i]) == '0);
    end

    always_comb begin
        kinds = '0;
        for (int i = 0; i < N_RANGES; i++) begin
            if (hit[i]) kinds = kinds | kind_bit(attr_q[i].kind);
        end
    end

endmodule

// File: rtl/memtype_merge.sv
module memtype_merge
    import memtype_pkg::*;
(
    input  kind_set_t   kinds,
    input  mem_type_e   dflt,
    input  logic [2:0]  page_code,
    output resolved_t   result
);

    mem_type_e range_kind;
    mem_type_e final_kind;

    always_comb begin
        range_kind       = resolve_overlap(kinds, dflt);
        final_kind       = merge_page(range_kind, sanitize(page_code));
        result.kind      = final_kind;
        result.cacheable = is_cacheable(final_kind);
    end

endmodule

// File: rtl/memtype_resolver.sv
module memtype_resolver
    import memtype_pkg::*;
#(
    parameter int N_RANGES   = 8,
    parameter int PA_W       = 36,
    parameter int PAGE_SHIFT = 12,
    localparam int PFN_W     = PA_W - PAGE_SHIFT,
    localparam int IDX_W     = (N_RANGES > 1) ? $clog2(N_RANGES) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [PFN_W-1:0] cfg_base,
    input  logic [PFN_W-1:0] cfg_mask,
    input  logic             cfg_valid,
    input  logic [2:0]       cfg_type,
    input  logic             def_we,
    input  logic [2:0]       def_type,
    input  logic             fill_req,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic [2:0]       fill_pat,
    output logic             res_valid,
    output logic [2:0]       res_type,
    output logic             res_cacheable,
    output logic             tlb_flush_all
);

    logic [N_RANGES-1:0][PFN_W-1:0] base_q;
    logic [N_RANGES-1:0][PFN_W-1:0] mask_q;
    range_attr_t [N_RANGES-1:0]     attr_q;
    mem_type_e                      dflt_q;
    kind_set_t                      kinds;
    resolved_t                      res_d;
    resolved_t                      res_q;

    memtype_range_regs #(.N_RANGES(N_RANGES), .PFN_W(PFN_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (cfg_we),
        .wr_idx    (cfg_idx),
        .wr_base   (cfg_base),
        .wr_mask   (cfg_mask),
        .wr_enable (cfg_valid),
        .wr_type   (cfg_type),
        .dflt_we   (def_we),
        .dflt_type (def_type),
        .base_q    (base_q),
        .mask_q    (mask_q),
        .attr_q    (attr_q),
        .dflt_q    (dflt_q)
    );

    memtype_range_match #(.N_RANGES(N_RANGES), .PFN_W(PFN_W)) u_match (
        .pfn    (fill_pfn),
        .base_q (base_q),
        .mask_q (mask_q),
        .attr_q (attr_q),
        .kinds  (kinds)
    );

    memtype_merge u_merge (
        .kinds     (kinds),
        .dflt      (dflt_q),
        .page_code (fill_pat),
        .result    (res_d)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid     <= 1'b0;
            res_q         <= '{kind: MT_UC, cacheable: 1'b0};
            tlb_flush_all <= 1'b0;
        end else begin
            res_valid     <= fill_req;
            tlb_flush_all <= cfg_we || def_we;
            if (fill_req) res_q <= res_d;
        end
    end

    assign res_type      = res_q.kind;
    assign res_cacheable = res_q.cacheable;

endmodule

// File: rtl/memtype_resolver_chk.sv
module memtype_resolver_chk (
    input logic       clk,
    input logic       rst,
    input logic       cfg_we,
    input logic       def_we,
    input logic       fill_req,
    input logic [2:0] fill_pat,
    input logic       res_valid,
    input logic [2:0] res_type,
    input logic       res_cacheable,
    input logic       tlb_flush_all
);

    assert_reset_quiet_R10: assert property (@(posedge clk)
        rst |=> (!res_valid && !tlb_flush_all));

    assert_flush_after_write_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_we || def_we) |=> tlb_flush_all);

    assert_no_spurious_flush_R8: assert property (@(posedge clk) disable iff (rst)
        !(cfg_we || def_we) |=> !tlb_flush_all);

    assert_result_follows_fill_R7: assert property (@(posedge clk) disable iff (rst)
        fill_req |=> res_valid);

    assert_no_result_without_fill_R7: assert property (@(posedge clk) disable iff (rst)
        !fill_req |=> !res_valid);

    assert_legal_type_R1: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_type inside {3'd0, 3'd1, 3'd4, 3'd5, 3'd6}));

    assert_page_uc_wins_R5: assert property (@(posedge clk) disable iff (rst)
        (fill_req && fill_pat == 3'd0) |=> (res_type == 3'd0));

    assert_uncached_kinds_R6: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_type inside {3'd0, 3'd1}) |-> !res_cacheable);

    assert_cached_kinds_R6: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_type inside {3'd4, 3'd5, 3'd6}) |-> res_cacheable);

endmodule

bind memtype_resolver memtype_resolver_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .cfg_we        (cfg_we),
    .def_we        (def_we),
    .fill_req      (fill_req),
    .fill_pat      (fill_pat),
    .res_valid     (res_valid),
    .res_type      (res_type),
    .res_cacheable (res_cacheable),
    .tlb_flush_all (tlb_flush_all)
);

// File: tb/memtype_resolver_test.sv
`timescale 1ns/1ps
module memtype_resolver_test;

    localparam int NR = 8;
    localparam int PW = 24;
    localparam logic [2:0] UC = 3'd0, WC = 3'd1, WT = 3'd4, WP = 3'd5, WB = 3'd6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cfg_we = 0, cfg_valid = 0, def_we = 0, fill_req = 0;
    logic [2:0] cfg_idx = 0, cfg_type = 0, def_type = 0, fill_pat = 0;
    logic [PW-1:0] cfg_base = 0, cfg_mask = 0, fill_pfn = 0;
    logic res_valid, res_cacheable, tlb_flush_all;
    logic [2:0] res_type;

    always #2.5 clk = ~clk;

    memtype_resolver uut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_base(cfg_base), .cfg_mask(cfg_mask), .cfg_valid(cfg_valid),
        .cfg_type(cfg_type), .def_we(def_we), .def_type(def_type),
        .fill_req(fill_req), .fill_pfn(fill_pfn), .fill_pat(fill_pat),
        .res_valid(res_valid), .res_type(res_type),
        .res_cacheable(res_cacheable), .tlb_flush_all(tlb_flush_all)
    );

    int checks = 0, errors = 0;
    logic [PW-1:0] m_base [NR];
    logic [PW-1:0] m_mask [NR];
    logic          m_en   [NR];
    logic [2:0]    m_type [NR];
    logic [2:0]    m_dflt;

    logic   have_prev = 0, e_valid = 0, e_cache = 0, e_flush = 0;
    logic [2:0] e_type = 0;
    string  e_tag = "";

    function automatic logic [2:0] legal(input logic [2:0] c);
        return (c inside {WC, WT, WP, WB}) ? c : UC;
    endfunction

    function automatic logic [2:0] model_type(input logic [PW-1:0] pfn, input logic [2:0] pat);
        bit f_uc = 0, f_wc = 0, f_wt = 0, f_wp = 0, f_wb = 0;
        int kinds;
        logic [2:0] rt, pt;
        for (int i = 0; i < NR; i++) begin
            if (m_en[i] && ((pfn & m_mask[i]) == (m_base[i] & m_mask[i]))) begin
                case (m_type[i])
                    WC: f_wc = 1; WT: f_wt = 1; WP: f_wp = 1; WB: f_wb = 1;
                    default: f_uc = 1;
                endcase
            end
        end
        kinds = int'(f_uc) + int'(f_wc) + int'(f_wt) + int'(f_wp) + int'(f_wb);
        if (kinds == 0) rt = m_dflt;
        else if (kinds == 1) rt = f_uc ? UC : f_wc ? WC : f_wt ? WT : f_wp ? WP : WB;
        else if (kinds == 2 && f_wt && f_wb) rt = WT;
        else rt = UC;
        pt = legal(pat);
        if (rt == UC || pt == UC) return UC;
        if (rt == WC || pt == WC) return WC;
        if (rt == WT || pt == WT) return WT;
        return rt;
    endfunction

    task automatic check(input logic ok, input string tag, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    task automatic check_prev();
        if (!have_prev) return;
        check(res_valid == e_valid, "R7", "res_valid", res_valid, e_valid);
        check(tlb_flush_all == e_flush, "R8", "tlb_flush_all", tlb_flush_all, e_flush);
        if (e_valid && res_valid) begin
            check(res_type == e_type, e_tag, "res_type", res_type, e_type);
            check(res_cacheable == e_cache, "R6", "res_cacheable", res_cacheable, e_cache);
        end
    endtask

    task automatic step(input logic f, input logic [PW-1:0] pfn, input logic [2:0] pat,
                        input logic w, input logic [2:0] idx, input logic [PW-1:0] b,
                        input logic [PW-1:0] m, input logic v, input logic [2:0] t,
                        input logic dw, input logic [2:0] dt, input string tag);
        check_prev();
        fill_req = f; fill_pfn = pfn; fill_pat = pat;
        cfg_we = w; cfg_idx = idx; cfg_base = b; cfg_mask = m; cfg_valid = v; cfg_type = t;
        def_we = dw; def_type = dt;
        e_valid = f;
        e_type  = model_type(pfn, pat);
        e_cache = (e_type inside {WT, WP, WB});
        e_flush = w || dw;
        e_tag   = tag;
        have_prev = 1;
        if (w) begin
            m_base[idx] = b; m_mask[idx] = m; m_en[idx] = v; m_type[idx] = legal(t);
        end
        if (dw) m_dflt = legal(dt);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] idx, input logic [PW-1:0] b, input logic [PW-1:0] m,
                      input logic v, input logic [2:0] t);
        step(0, 0, WB, 1, idx, b, m, v, t, 0, UC, "R8");
    endtask

    task automatic fill(input logic [PW-1:0] pfn, input logic [2:0] pat, input string tag);
        step(1, pfn, pat, 0, 0, 0, 0, 0, UC, 0, UC, tag);
    endtask

    initial begin
        #1000000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [2:0] tset [5];
        logic [PW-1:0] msk [4];
        tset[0] = UC; tset[1] = WC; tset[2] = WT; tset[3] = WP; tset[4] = WB;
        msk[0] = 24'hF00000; msk[1] = 24'hFF0000; msk[2] = 24'hFFF000; msk[3] = 24'hFFFFFF;
        for (int i = 0; i < NR; i++) begin
            m_base[i] = 0; m_mask[i] = 0; m_en[i] = 0; m_type[i] = UC;
        end
        m_dflt = UC;
        void'($urandom(32'd4711));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        // R10: reset state at the ports
        check(res_valid == 0, "R10", "res_valid after reset", res_valid, 0);
        check(tlb_flush_all == 0, "R10", "flush after reset", tlb_flush_all, 0);
        // R3 / R10: nothing enabled, default is UC
        fill(24'h123456, WB, "R3");
        // R3: new default applies
        step(0, 0, WB, 0, 0, 0, 0, 0, UC, 1, WB, "R8");
        fill(24'h123456, WP, "R3");
        fill(24'h654321, WB, "R3");
        // R2: single range, 4 KB granularity on page numbers
        wr(3'd1, 24'h400000, 24'hF00000, 1, WP);
        fill(24'h4ABCDE, WB, "R2");
        fill(24'h5ABCDE, WB, "R2");
        // R4: overlaps
        wr(3'd2, 24'h400000, 24'hFF0000, 1, WB);
        fill(24'h40F000, WB, "R4");
        wr(3'd1, 24'h400000, 24'hF00000, 1, WT);
        fill(24'h40F000, WB, "R4");
        fill(24'h41F000, WB, "R4");
        wr(3'd3, 24'h40F000, 24'hFFF000, 1, UC);
        fill(24'h40F123, WB, "R4");
        wr(3'd3, 24'h40F000, 24'hFFF000, 1, WC);
        fill(24'h40F123, WB, "R4");
        // R5: page merge
        wr(3'd3, 24'h0, 24'h0, 0, UC);
        wr(3'd1, 24'h400000, 24'hF00000, 1, WB);
        wr(3'd2, 24'h0, 24'h0, 0, UC);
        fill(24'h400000, WC, "R5");
        fill(24'h400000, WT, "R5");
        fill(24'h400000, WP, "R5");
        fill(24'h400000, UC, "R5");
        // R1: reserved codes act as UC
        fill(24'h400000, 3'd7, "R1");
        wr(3'd4, 24'h800000, 24'hF00000, 1, 3'd3);
        fill(24'h812345, WB, "R1");
        // R9: fill and write in the same cycle use the old contents
        step(1, 24'h412345, WB, 1, 3'd1, 24'h400000, 24'hF00000, 1, WC, 0, UC, "R9");
        fill(24'h412345, WB, "R9");
        step(1, 24'h999999, WB, 0, 0, 0, 0, 0, UC, 1, WT, "R9");
        fill(24'h999999, WB, "R9");
        // Random mix, R4/R5
        for (int n = 0; n < 3000; n++) begin
            int op;
            logic [PW-1:0] b, p;
            op = int'($urandom % 5);
            b = {4'($urandom), 20'($urandom)};
            p = {4'($urandom), 20'($urandom)};
            if ($urandom % 2) p[19:12] = b[19:12];
            step(op != 1 && op != 4, p, tset[$urandom % 5],
                 op == 1 || op == 2, 3'($urandom), b, msk[$urandom % 4],
                 ($urandom % 4) != 0, tset[$urandom % 5],
                 op == 2 && ($urandom % 8 == 0), tset[$urandom % 5], "R4R5");
        end
        step(0, 0, WB, 0, 0, 0, 0, 0, UC, 0, UC, "R7");
        check_prev();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule